// File: doc/BRIEF.md
# Comma-Driven Even/Odd Code Group Aligner

This block sits after the deserializer and elastic buffer of a ten-bit serial receiver. It takes one 8b/10b code group per accepted transfer and passes it on two cycles later with a phase tag, even or odd, so that comma code groups leave in the even slot. It locks its phase on the first comma it sees after reset. While it has no lock, it reports a "not byte sync" status instead of the data.

A mode input, `en_realign`, controls what happens to later commas. When it is low, the phase stays where the first comma put it, and a later comma can leave in the odd slot. When it is high, a clean comma that would land in the odd slot is pushed into the even slot. The block does this by sending the last non-comma output a second time.

Each output carries the group's two top bits as data-valid and error flags, plus the low byte and a comma flag. When overrun, underrun or "not byte sync" applies, the block puts a status code byte in its place, and the highest-priority condition wins. The input side is valid/ready. `in_ready` drops for exactly one cycle for each repeat, and the upstream source must then hold its group. The output side has a valid strobe only. The sink has to take every group while `out_valid` is high, because the block cannot be stalled from downstream.

Top module: `comma_aligner`

## Requirements
- R1: A group counts as a comma when its bits [6:0] equal 7'h7C or 7'h03. This covers K28.1, K28.5 and K28.7 in either disparity, with bit 0 as the first bit on the line. Only a comma group sets `out_comma`.
- R2: After reset, the first comma received takes the lock and leaves with `out_odd` = 0, whatever the phase counter holds at that point.
- R3: Until lock, every output has `out_err` = 1, `out_byte` = 8'h00, `out_dv` = 0 and `out_comma` = 0. This holds even when overrun or underrun is flagged with the group.
- R4: `out_odd` is 0 for the first output after reset. It then toggles on every output, including repeats, except when R2 forces it to 0.
- R5: With `en_realign` low, a comma after lock that falls in the odd slot leaves odd, and `in_ready` stays high.
- R6: With `en_realign` high, a comma after lock with no overrun or underrun that would fall odd causes the previous output to be sent again, tagged odd. `in_ready` is low for that one cycle, and the comma follows tagged even.
- R7: No repeat happens when the previous output was itself a comma, or when the comma carries overrun or underrun.
- R8: Once locked, overrun gives `out_err` = 1 with `out_byte` = 8'h04. Underrun gives `out_err` = 1 with `out_byte` = 8'h02. When both are flagged, overrun wins. In all these cases `out_dv` = 0 and `out_comma` = 0.
- R9: Once locked and with no error, `out_dv` is bit 9, `out_err` is bit 8 and `out_byte` is bits [7:0] of the group.
- R10: A group accepted at one rising edge appears at the output after the second rising edge. A cycle with no accepted group, and no repeat pending, gives `out_valid` = 0.
- R11: A synchronous reset clears the lock and the phase counter, drives `out_valid` low and `in_ready` high, and brings back the not-byte-sync status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_realign | input | 1 | Allows realignment on commas after lock |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block accepts the group this cycle |
| in_code | input | 10 | 8b/10b code group, bit 0 first on the line |
| in_ovr | input | 1 | Overrun flagged with this group |
| in_udr | input | 1 | Underrun flagged with this group |
| out_valid | output | 1 | Output group valid |
| out_odd | output | 1 | Phase tag: 0 = even slot, 1 = odd slot |
| out_dv | output | 1 | Data-valid flag |
| out_err | output | 1 | Error flag |
| out_byte | output | 8 | Data byte or status code |
| out_comma | output | 1 | Group is a comma |

## Verification
The bench uses the package widths as they stand: a 10-bit code group and an 8-bit byte. The commas tested are K28.1, K28.5 and K28.7. K28.0 is the look-alike non-comma. With these widths, every comma pattern and every status code can be written directly into the vector table. The repeat path, with its one-cycle stall and the cases where it is refused, is driven by directed sequences whose outputs are captured and compared in order.

// File: rtl/aln_pkg.sv
package aln_pkg;
  localparam int CODE_W = 10;
  localparam int BYTE_W = CODE_W - 2;
  localparam int MARK_W = 7;
  localparam logic [MARK_W-1:0] MARK_NEG = 7'h7C;
  localparam logic [MARK_W-1:0] MARK_POS = 7'h03;
  localparam logic [BYTE_W-1:0] ST_NOSYNC = 8'h00;
  localparam logic [BYTE_W-1:0] ST_UNDER  = 8'h02;
  localparam logic [BYTE_W-1:0] ST_OVER   = 8'h04;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ovr;
    logic              udr;
    logic              comma;
  } grp_t;

  function automatic logic is_comma(input logic [CODE_W-1:0] c);
    return (c[MARK_W-1:0] == MARK_NEG) || (c[MARK_W-1:0] == MARK_POS);
  endfunction
endpackage

// File: rtl/aln_stage.sv
module aln_stage
  import aln_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_ovr,
  input  logic              in_udr,
  output logic              s1_v,
  output grp_t              s1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1   <= '0;
    end else if (ld) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1.code  <= in_code;
        s1.ovr   <= in_ovr;
        s1.udr   <= in_udr;
        s1.comma <= is_comma(in_code);
      end
    end
  end

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && s1_v) |=> (s1_v && $stable(s1)));
endmodule

// File: rtl/aln_phase.sv
module aln_phase
  import aln_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s1_v,
  input  grp_t s1,
  input  logic en_realign,
  input  logic last_comma,
  output logic emit,
  output logic rep,
  output logic tag,
  output logic sync
);
  logic locked, nxt_odd;

  always_comb begin
    emit = s1_v;
    sync = locked || s1.comma;
    tag  = (!locked && s1.comma) ? 1'b0 : nxt_odd;
    rep  = s1_v && locked && nxt_odd && s1.comma && !s1.ovr && !s1.udr
           && en_realign && !last_comma;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      nxt_odd <= 1'b0;
    end else if (emit) begin
      nxt_odd <= !tag;
      if (s1.comma) locked <= 1'b1;
    end
  end

  // R6
  single_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    rep |=> !rep);
  // R2
  lock_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

// File: rtl/aln_fmt.sv
module aln_fmt
  import aln_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic              rep,
  input  logic              tag,
  input  logic              sync,
  input  grp_t              s1,
  output logic              out_valid,
  output logic              out_odd,
  output logic              out_dv,
  output logic              out_err,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_comma
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_odd   <= 1'b0;
      out_dv    <= 1'b0;
      out_err   <= 1'b0;
      out_byte  <= '0;
      out_comma <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_odd <= tag;
        if (!rep) begin
          if (!sync || s1.ovr || s1.udr) begin
            out_dv    <= 1'b0;
            out_err   <= 1'b1;
            out_comma <= 1'b0;
            out_byte  <= !sync ? ST_NOSYNC : (s1.ovr ? ST_OVER : ST_UNDER);
          end else begin
            out_dv    <= s1.code[CODE_W-1];
            out_err   <= s1.code[CODE_W-2];
            out_byte  <= s1.code[BYTE_W-1:0];
            out_comma <= s1.comma;
          end
        end
      end
    end
  end

  // R6
  repeat_is_odd_chk: assert property (@(posedge clk) disable iff (rst)
    rep |=> (out_valid && out_odd));
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import aln_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_realign,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_ovr,
  input  logic              in_udr,
  output logic              out_valid,
  output logic              out_odd,
  output logic              out_dv,
  output logic              out_err,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_comma
);
  logic s1_v, emit, rep, tag, sync;
  grp_t s1;

  assign in_ready = !rep;

  aln_stage u_stage (
    .clk(clk), .rst(rst), .ld(in_ready), .in_valid(in_valid),
    .in_code(in_code), .in_ovr(in_ovr), .in_udr(in_udr),
    .s1_v(s1_v), .s1(s1)
  );

  aln_phase u_phase (
    .clk(clk), .rst(rst), .s1_v(s1_v), .s1(s1), .en_realign(en_realign),
    .last_comma(out_comma), .emit(emit), .rep(rep), .tag(tag), .sync(sync)
  );

  aln_fmt u_fmt (
    .clk(clk), .rst(rst), .emit(emit), .rep(rep), .tag(tag), .sync(sync),
    .s1(s1), .out_valid(out_valid), .out_odd(out_odd), .out_dv(out_dv),
    .out_err(out_err), .out_byte(out_byte), .out_comma(out_comma)
  );

  // R5
  no_stall_when_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !en_realign |-> in_ready);
  // R6
  comma_even_after_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ##1 (out_valid && out_comma && !out_odd));
endmodule

// File: tb/test_comma_aligner.sv
module test_comma_aligner;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, en_realign = 1'b0, in_valid = 1'b0;
  logic [9:0] in_code = '0;
  logic in_ovr = 1'b0, in_udr = 1'b0;
  logic in_ready, out_valid, out_odd, out_dv, out_err, out_comma;
  logic [7:0] out_byte;

  comma_aligner i_comma_aligner (
    .clk(clk), .rst(rst), .en_realign(en_realign), .in_valid(in_valid),
    .in_ready(in_ready), .in_code(in_code), .in_ovr(in_ovr), .in_udr(in_udr),
    .out_valid(out_valid), .out_odd(out_odd), .out_dv(out_dv),
    .out_err(out_err), .out_byte(out_byte), .out_comma(out_comma)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic v; logic [9:0] code; logic ovr; logic udr;
    logic odd; logic dv; logic err; logic [7:0] byt; logic com;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},
    '{1'b1, 10'h0C3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
    '{1'b1, 10'h2AA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},
    '{1'b1, 10'h27C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7C, 1'b1},
    '{1'b1, 10'h0C3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b0},
    '{1'b1, 10'h283, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h83, 1'b1},
    '{1'b1, 10'h17C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h7C, 1'b1},
    '{1'b1, 10'h2AA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0},
    '{1'b1, 10'h2AA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02, 1'b0},
    '{1'b1, 10'h2AA, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0},
    '{1'b1, 10'h17C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h02, 1'b0},
    '{1'b1, 10'h2AA, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hAA, 1'b0},
    '{1'b1, 10'h07C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h7C, 1'b1},
    '{1'b1, 10'h0BC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hBC, 1'b0},
    '{1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0}
  };

  logic [11:0] cap [16];
  int ncap = 0;
  logic cap_on = 1'b0;

  always @(posedge clk)
    if (cap_on && !rst && out_valid && ncap < 16) begin
      cap[ncap] <= {out_odd, out_dv, out_err, out_comma, out_byte};
      ncap <= ncap + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] c, input logic ov, input logic ud, inout int stalls);
    logic ok;
    in_valid = 1'b1; in_code = c; in_ovr = ov; in_udr = ud;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
      stalls++;
    end
  endtask

  task automatic flush();
    in_valid = 1'b0; in_ovr = 1'b0; in_udr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic restart(input logic en);
    rst = 1'b1; en_realign = en; cap_on = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; ncap = 0; cap_on = 1'b1;
  endtask

  function automatic string row_req(input int r);
    if (r < 3) return "R3";
    if (r == 3) return "R2";
    if (r == 6) return "R5";
    if (r >= 7 && r <= 10) return "R8";
    return "R9";
  endfunction

  initial begin
    #(PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st;
    @(negedge clk);
    @(negedge clk);
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset in_ready", in_ready, 1);
    rst = 1'b0;

    // vector table, en_realign low, outputs due two cycles after drive (R10)
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk("R10 valid", out_valid, TBL[i-2].v);
        if (TBL[i-2].v) begin
          chk("R4 tag", out_odd, TBL[i-2].odd);
          chk(row_req(i-2), {out_dv, out_err, out_byte}, {TBL[i-2].dv, TBL[i-2].err, TBL[i-2].byt});
          chk("R1 comma flag", out_comma, TBL[i-2].com);
          chk("R5 ready", in_ready, 1);
        end
      end
      if (i < NV) begin
        in_valid = TBL[i].v; in_code = TBL[i].code; in_ovr = TBL[i].ovr; in_udr = TBL[i].udr;
      end else begin
        in_valid = 1'b0; in_ovr = 1'b0; in_udr = 1'b0;
      end
      @(negedge clk);
    end

    // R6: repeat of last data group moves comma to even
    restart(1'b1); st = 0;
    send(10'h27C, 0, 0, st); send(10'h0C3, 0, 0, st); send(10'h2AA, 0, 0, st);
    send(10'h283, 0, 0, st); send(10'h0C3, 0, 0, st);
    flush();
    chk("R6 count", ncap, 6);
    chk("R6 stalls", st, 1);
    chk("R6 out0", cap[0], {4'b0101, 8'h7C});
    chk("R6 out1", cap[1], {4'b1000, 8'hC3});
    chk("R6 out2", cap[2], {4'b0100, 8'hAA});
    chk("R6 repeat", cap[3], {4'b1100, 8'hAA});
    chk("R6 comma even", cap[4], {4'b0101, 8'h83});
    chk("R6 out5", cap[5], {4'b1000, 8'hC3});

    // R7: previous output a comma, no repeat
    restart(1'b1); st = 0;
    send(10'h27C, 0, 0, st); send(10'h17C, 0, 0, st);
    flush();
    chk("R7 count", ncap, 2);
    chk("R7 stalls", st, 0);
    chk("R7 odd comma", cap[1], {4'b1011, 8'h7C});

    // R7 and R8: comma with overrun falls odd, not repeated
    restart(1'b1); st = 0;
    send(10'h27C, 0, 0, st); send(10'h0C3, 0, 0, st); send(10'h2AA, 0, 0, st);
    send(10'h283, 1, 0, st);
    flush();
    chk("R7 count ovr", ncap, 4);
    chk("R7 stalls ovr", st, 0);
    chk("R8 ovr comma", cap[3], {4'b1010, 8'h04});

    // R11: reset after lock returns not-byte-sync and even phase
    restart(1'b0); st = 0;
    send(10'h27C, 0, 0, st); send(10'h0C3, 0, 0, st);
    flush();
    restart(1'b0);
    chk("R11 valid after reset", out_valid, 0);
    send(10'h2AA, 0, 0, st);
    flush();
    chk("R11 count", ncap, 1);
    chk("R11 nosync", cap[0], {4'b0010, 8'h00});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule